// File: doc/BRIEF.md
# Dual Lookup-Table Logic Cell with Distributed RAM

The cell holds two 16-entry, 1-bit lookup tables, called F and G, each addressed by its own 4-bit input group. A third function, H, merges the two table outputs with an extra input through an 8-bit truth table. The same two tables double as small synchronous-write memories. A 2-bit mode input picks one of four arrangements: two independent 16x1 tables, one 32x1 memory, one 16x2 memory, or one 16x1 memory with a second read-only port.

Every read is combinational. Writes are sampled on the rising edge of the single clock. Loading a truth table is an ordinary memory write, so logic use is simply the split arrangement after its tables have been filled. Two registers on the same clock capture the F and H results, and an active-low asynchronous reset clears them. Reset does not touch the table contents.

Top module: `dual_lut_cell`

## Requirements
- R1: In split mode (mode = 0), fOut is F table bit fAddr and gOut is G table bit gAddr. The two lookups are independent.
- R2: hOut is bit {hIn, gOut, fOut} of hTable in every mode, with hIn as the most significant index bit and fOut as the least.
- R3: A table bit changes only at a rising clock edge with its write enable set. A read of the address being written returns the old contents until that edge, and the new contents after it.
- R4: In wide mode (mode = 1) the tables form one 32x1 memory addressed by {hIn, fAddr}, with hIn = 1 selecting the G half. wrEn[0] writes wrData[0], and fOut returns the addressed bit.
- R5: In pair mode (mode = 2) the tables form one 16x2 memory at fAddr. wrEn[0] stores wrData[1:0], with bit 0 going to F and bit 1 going to G. fOut and gOut return bits 0 and 1.
- R6: In dual-port mode (mode = 3), wrEn[0] writes wrData[0] into both tables at fAddr. fOut reads at fAddr and gOut reads at rdAddr. gAddr, wrData[1] and wrEn[1] have no effect.
- R7: fQ and hQ take fOut and hOut at each rising edge. While rstN is low they are 0.
- R8: In split mode, wrEn[0] writes wrData[0] into F at fAddr and wrEn[1] writes wrData[1] into G at gAddr. Neither enable touches the other table.
- R9: With wrEn = 0 no table bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and register clock |
| rstN | input | 1 | Active-low asynchronous reset of fQ and hQ |
| mode | input | 2 | 0 split, 1 wide 32x1, 2 pair 16x2, 3 dual-port 16x1 |
| fAddr | input | 4 | F address; write address in wide, pair and dual-port modes |
| gAddr | input | 4 | G address in split mode |
| rdAddr | input | 4 | Read-only port address in dual-port mode |
| hIn | input | 1 | Extra H input; address bit 4 in wide mode |
| hTable | input | 8 | Truth table of H |
| wrEn | input | 2 | Write enables |
| wrData | input | 2 | Write data |
| fOut | output | 1 | Combinational F result |
| gOut | output | 1 | Combinational G result |
| hOut | output | 1 | Combinational H result |
| fQ | output | 1 | Registered F result |
| hQ | output | 1 | Registered H result |

## Verification
fOut, gOut and hOut follow a change of address, mode, hIn or hTable within the same cycle. The bench drives inputs on the falling edge and samples these outputs two nanoseconds later. A write shows on the read outputs only after the next rising edge, so every write check samples once before that edge, where it expects the old value, and once just after it. fQ and hQ take one rising edge, and they are read one nanosecond after the edge that captures the values the bench set up on the previous falling edge.

// File: rtl/dual_lut_pkg.sv
package dual_lut_pkg;
  parameter int LUT_K = 4;
  localparam int LUT_DEPTH = 1 << LUT_K;
  localparam int NUM_LUTS = 2;
  localparam int H_INPUTS = 3;
  localparam int H_SIZE = 1 << H_INPUTS;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_PAIR  = 2'd2,
    MODE_DUAL  = 2'd3
  } lutMode_t;

  typedef struct packed {
    logic [NUM_LUTS-1:0]            we;
    logic [NUM_LUTS-1:0][LUT_K-1:0] wrAddr;
    logic [NUM_LUTS-1:0]            wrBit;
    logic [LUT_K-1:0]               gRdAddr;
    logic                           fFromG;
  } lutCtrl_t;
endpackage

// File: rtl/lut_mem.sv
module lut_mem #(
  parameter int AddrW = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AddrW-1:0] wrAddr,
  input  logic             wrBit,
  input  logic [AddrW-1:0] rdAddr,
  output logic             rdBit
);
  localparam int Depth = 1 << AddrW;

  logic [Depth-1:0] cells;

  always_ff @(posedge clk) begin
    if (we) cells[wrAddr] <= wrBit;
  end

  assign rdBit = cells[rdAddr];
endmodule

// File: rtl/dual_lut_ctrl.sv
module dual_lut_ctrl
  import dual_lut_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [LUT_K-1:0] fAddr,
  input  logic [LUT_K-1:0] gAddr,
  input  logic [LUT_K-1:0] rdAddr,
  input  logic             hIn,
  input  logic [1:0]       wrEn,
  input  logic [1:0]       wrData,
  output lutCtrl_t         ctrl
);
  lutMode_t modeSel;

  always_comb begin
    modeSel = lutMode_t'(mode);
    ctrl = '0;
    ctrl.wrAddr[0] = fAddr;
    ctrl.wrAddr[1] = fAddr;
    ctrl.wrBit[0] = wrData[0];
    ctrl.wrBit[1] = wrData[0];
    ctrl.gRdAddr = fAddr;
    unique case (modeSel)
      MODE_SPLIT: begin
        ctrl.we = wrEn;
        ctrl.wrAddr[1] = gAddr;
        ctrl.wrBit[1] = wrData[1];
        ctrl.gRdAddr = gAddr;
      end
      MODE_WIDE: begin
        ctrl.we[0] = wrEn[0] & ~hIn;
        ctrl.we[1] = wrEn[0] & hIn;
        ctrl.fFromG = hIn;
      end
      MODE_PAIR: begin
        ctrl.we = {2{wrEn[0]}};
        ctrl.wrBit[1] = wrData[1];
      end
      MODE_DUAL: begin
        ctrl.we = {2{wrEn[0]}};
        ctrl.gRdAddr = rdAddr;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/dual_lut_dp.sv
module dual_lut_dp
  import dual_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lutCtrl_t          ctrl,
  input  logic [LUT_K-1:0]  fAddr,
  input  logic              hIn,
  input  logic [H_SIZE-1:0] hTable,
  output logic              fOut,
  output logic              gOut,
  output logic              hOut,
  output logic              fQ,
  output logic              hQ
);
  logic [NUM_LUTS-1:0]            rdBits;
  logic [NUM_LUTS-1:0][LUT_K-1:0] rdAddrs;

  assign rdAddrs[0] = fAddr;
  assign rdAddrs[1] = ctrl.gRdAddr;

  for (genvar i = 0; i < NUM_LUTS; i++) begin : g_lut
    lut_mem #(.AddrW(LUT_K)) mem_i (
      .clk    (clk),
      .we     (ctrl.we[i]),
      .wrAddr (ctrl.wrAddr[i]),
      .wrBit  (ctrl.wrBit[i]),
      .rdAddr (rdAddrs[i]),
      .rdBit  (rdBits[i])
    );
  end

  assign fOut = ctrl.fFromG ? rdBits[1] : rdBits[0];
  assign gOut = rdBits[1];
  assign hOut = hTable[{hIn, gOut, fOut}];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fQ <= 1'b0;
      hQ <= 1'b0;
    end else begin
      fQ <= fOut;
      hQ <= hOut;
    end
  end
endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell
  import dual_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [LUT_K-1:0]  fAddr,
  input  logic [LUT_K-1:0]  gAddr,
  input  logic [LUT_K-1:0]  rdAddr,
  input  logic              hIn,
  input  logic [H_SIZE-1:0] hTable,
  input  logic [1:0]        wrEn,
  input  logic [1:0]        wrData,
  output logic              fOut,
  output logic              gOut,
  output logic              hOut,
  output logic              fQ,
  output logic              hQ
);
  lutCtrl_t ctrl;

  dual_lut_ctrl ctrl_i (
    .mode   (mode),
    .fAddr  (fAddr),
    .gAddr  (gAddr),
    .rdAddr (rdAddr),
    .hIn    (hIn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .ctrl   (ctrl)
  );

  dual_lut_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .fAddr  (fAddr),
    .hIn    (hIn),
    .hTable (hTable),
    .fOut   (fOut),
    .gOut   (gOut),
    .hOut   (hOut),
    .fQ     (fQ),
    .hQ     (hQ)
  );
endmodule

// File: rtl/dual_lut_cell_chk.sv
module dual_lut_cell_chk
  import dual_lut_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic [LUT_K-1:0]  fAddr,
  input logic              hIn,
  input logic [H_SIZE-1:0] hTable,
  input logic [1:0]        wrEn,
  input logic [1:0]        wrData,
  input logic              fOut,
  input logic              gOut,
  input logic              hOut,
  input logic              fQ,
  input logic              hQ
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R7: registered F follows the combinational F one edge later
  a_r7_fq_follows: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> fQ == $past(fOut));

  // R2: registered H matches the truth table lookup of the previous cycle
  a_r2_hq_table: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> hQ == $past(hTable[{hIn, gOut, fOut}]));

  // R3: a split-mode F write is visible after the edge at the same address
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && wrEn[0]) |=>
      (mode != 2'd0 || fAddr != $past(fAddr) || fOut == $past(wrData[0])));

  // R9: without a write the F read at a held address is unchanged
  a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && wrEn == 2'b00) |=>
      (mode != 2'd0 || fAddr != $past(fAddr) || fOut == $past(fOut)));

  // R5: a pair-mode write stores both bits
  a_r5_pair_write: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && wrEn[0]) |=>
      (mode != 2'd2 || fAddr != $past(fAddr) || {gOut, fOut} == $past(wrData)));

  // R7: registers stay clear while reset is held
  always @(negedge clk) begin
    if (!rstN) a_r7_reset_clear: assert (fQ == 1'b0 && hQ == 1'b0);
  end
endmodule

bind dual_lut_cell dual_lut_cell_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (mode),
  .fAddr  (fAddr),
  .hIn    (hIn),
  .hTable (hTable),
  .wrEn   (wrEn),
  .wrData (wrData),
  .fOut   (fOut),
  .gOut   (gOut),
  .hOut   (hOut),
  .fQ     (fQ),
  .hQ     (hQ)
);

// File: tb/dual_lut_cell_tb_top.sv
`timescale 1ns/1ps
module dual_lut_cell_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] mode;
  logic [3:0] fAddr, gAddr, rdAddr;
  logic       hIn;
  logic [7:0] hTable;
  logic [1:0] wrEn, wrData;
  logic       fOut, gOut, hOut, fQ, hQ;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // F bit i = parity of i, G bit i = i[3], H = majority of f, g, hIn
  localparam logic [15:0] F_INIT = 16'h6996;
  localparam logic [15:0] G_INIT = 16'hFF00;
  localparam logic [7:0]  H_MAJ  = 8'hE8;

  // {mode, fAddr, gAddr, rdAddr, hIn, expF, expG, expH}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'd1,  4'd8,  4'd0,  1'b0, 1'b1, 1'b1, 1'b1},
    {2'd0, 4'd3,  4'd7,  4'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'd7,  4'd15, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1},
    {2'd0, 4'd14, 4'd2,  4'd0,  1'b1, 1'b1, 1'b0, 1'b1},
    {2'd0, 4'd12, 4'd9,  4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 4'd5,  4'd0,  4'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'd9,  4'd0,  4'd0,  1'b1, 1'b1, 1'b1, 1'b1},
    {2'd1, 4'd9,  4'd0,  4'd0,  1'b0, 1'b0, 1'b1, 1'b0},
    {2'd3, 4'd1,  4'd0,  4'd12, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd2, 4'd10, 4'd0,  4'd0,  1'b0, 1'b0, 1'b1, 1'b0}
  };

  dual_lut_cell dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .fAddr(fAddr), .gAddr(gAddr),
    .rdAddr(rdAddr), .hIn(hIn), .hTable(hTable), .wrEn(wrEn), .wrData(wrData),
    .fOut(fOut), .gOut(gOut), .hOut(hOut), .fQ(fQ), .hQ(hQ)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setIn(input logic [1:0] m, input logic [3:0] fa, input logic [3:0] ga,
                       input logic [3:0] ra, input logic h);
    mode = m; fAddr = fa; gAddr = ga; rdAddr = ra; hIn = h;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    hTable = H_MAJ;
    wrEn = 2'b00; wrData = 2'b00;
    setIn(2'd0, 4'd1, 4'd0, 4'd0, 1'b0);
    // load both tables while reset holds the registers
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      setIn(2'd0, 4'(i), 4'(i), 4'd0, 1'b0);
      wrEn = 2'b11;
      wrData = {G_INIT[i], F_INIT[i]};
    end
    @(negedge clk);
    wrEn = 2'b00;
    setIn(2'd0, 4'd1, 4'd8, 4'd0, 1'b0);
    @(negedge clk);
    #2;
    check("R7 reset fQ", fQ, 1'b0);
    check("R7 reset hQ", hQ, 1'b0);
    rstN = 1'b1;

    // vector table: R1 split, R4 wide, R6 dual read, R5 pair read, R2 H, R7 registers
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      setIn(VEC[v][17:16], VEC[v][15:12], VEC[v][11:8], VEC[v][7:4], VEC[v][3]);
      #2;
      check("R1/R4/R5/R6 fOut", fOut, VEC[v][2]);
      check("R1/R4/R5/R6 gOut", gOut, VEC[v][1]);
      check("R2 hOut", hOut, VEC[v][0]);
      @(posedge clk); #1;
      check("R7 fQ", fQ, VEC[v][2]);
      check("R7 hQ", hQ, VEC[v][0]);
    end

    // R3: old value before the edge, new value after it
    @(negedge clk);
    setIn(2'd0, 4'd0, 4'd0, 4'd0, 1'b0);
    wrEn = 2'b01; wrData = 2'b01;
    #2;
    check("R3 old before edge", fOut, 1'b0);
    @(posedge clk); #1;
    check("R3 new after edge", fOut, 1'b1);

    // R8: G-only write leaves F alone
    @(negedge clk);
    setIn(2'd0, 4'd3, 4'd3, 4'd0, 1'b0);
    wrEn = 2'b10; wrData = 2'b11;
    @(posedge clk); #1;
    check("R8 G written", gOut, 1'b1);
    check("R8 F untouched", fOut, 1'b0);

    // R9: no enable, no change
    @(negedge clk);
    setIn(2'd0, 4'd5, 4'd5, 4'd0, 1'b0);
    wrEn = 2'b00; wrData = 2'b11;
    @(posedge clk); #1;
    check("R9 F held", fOut, 1'b0);
    check("R9 G held", gOut, 1'b0);

    // R4: wide write into the upper half at address 6
    @(negedge clk);
    setIn(2'd1, 4'd6, 4'd0, 4'd0, 1'b1);
    wrEn = 2'b01; wrData = 2'b01;
    @(posedge clk); #1;
    check("R4 upper half written", fOut, 1'b1);
    @(negedge clk);
    wrEn = 2'b00;
    hIn = 1'b0;
    #2;
    check("R4 lower half untouched", fOut, 1'b0);

    // R5: pair write of both bits at address 13
    @(negedge clk);
    setIn(2'd2, 4'd13, 4'd0, 4'd0, 1'b0);
    wrEn = 2'b01; wrData = 2'b10;
    #2;
    check("R5 F old", fOut, 1'b1);
    @(posedge clk); #1;
    check("R5 F bit0", fOut, 1'b0);
    check("R5 G bit1", gOut, 1'b1);

    // R6: dual-port write via fAddr, wrData[1]/wrEn[1]/gAddr ignored
    @(negedge clk);
    setIn(2'd3, 4'd2, 4'd4, 4'd2, 1'b0);
    wrEn = 2'b11; wrData = 2'b10;
    @(posedge clk); #1;
    check("R6 F written", fOut, 1'b0);
    check("R6 read port same addr", gOut, 1'b0);
    @(negedge clk);
    wrEn = 2'b00;
    rdAddr = 4'd15;
    #2;
    check("R6 read port other addr", gOut, 1'b1);
    check("R6 write port addr", fOut, 1'b0);
    @(negedge clk);
    setIn(2'd0, 4'd2, 4'd4, 4'd0, 1'b0);
    #2;
    check("R6 gAddr slot untouched", gOut, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule